// File: doc/BRIEF.md
# Single-Port Two-Pass Operand Read Scheduler

This block is the select and operand-read stage of one issue slot. The slot owns exactly one register-file read port. A small queue holds waiting instructions, each with zero, one or two sources. A wakeup tag bus marks sources ready. Each cycle the priority picker grants at most one ready entry. After a grant, the read sequencer fetches operands, announces the destination tag, and presents both operands to the functional unit.

A two-source instruction normally uses the port for only one of its values. The other value must come from the bypass network, and the bypass window is one cycle wide. So the bypass covers a source only when its wakeup tag appears in the same cycle the instruction is granted (back-to-back issue). If neither source qualifies, the instruction reads the port twice in consecutive cycles and holds the first value until the second arrives. It also announces its destination one cycle later than usual, and the slot grants nothing in the cycle right after the grant. The scheduler therefore sees the longer latency in advance, so dependants wake on time and no recovery is needed.

The source count `ins_nsrc` is 0, 1 or 2. Source A is in use when the count is at least 1, and source B only when it is 2. A source that is not in use counts as ready.

Top module: `seqread_sched`

## Requirements
- R1: After reset the block shows no grant, no broadcast, no read enable and no operand valid, and `q_full` is low.
- R2: An entry requests selection when every source it uses is ready. A source is ready if it was ready at insertion, was woken earlier, or matches `wake_tag` with `wake_valid` in the current cycle. An entry cannot be selected in the cycle it is inserted. The lowest-index requester wins, and at most one grant occurs per cycle.
- R3: For a grant with `grant_seq`=0 in cycle T, `bcast_tag` carries the destination in T+1. In T+1 the port reads the one used source not woken in T, if there is one. In T+2, `op_valid` rises: a source woken in T takes `byp_data`, and a read source takes `rf_rdata`.
- R4: A two-source instruction granted in a cycle in which neither of its sources was woken is granted with `grant_seq`=1. It reads source A in T+1 and source B in T+2. In T+3 it presents `op_a` as the first value read and `op_b` as the second.
- R5: In the cycle after a grant with `grant_seq`=1, no grant is made even if entries are ready. Grants resume in the cycle after that.
- R6: A grant with `grant_seq`=1 in cycle T broadcasts its destination in T+2, not in T+1. A dependant woken by that broadcast is therefore granted two cycles after the producer.
- R7: A zero- or one-source instruction is never sequential. A zero-source instruction makes no read, and an unused operand is presented as zero.
- R8: `q_full` is high when all entries are occupied. An insertion while `q_full` is high is ignored.
- R9: A two-source instruction whose last source was woken in an earlier cycle, and that was not granted in that cycle, is treated as sequential when it is later granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert an instruction this cycle |
| ins_nsrc | input | 2 | Number of sources in use (0, 1, 2) |
| ins_src_a | input | 3 | Source A register tag |
| ins_src_b | input | 3 | Source B register tag |
| ins_rdy_a | input | 1 | Source A already available at insertion |
| ins_rdy_b | input | 1 | Source B already available at insertion |
| ins_dest | input | 3 | Destination register tag |
| q_full | output | 1 | All queue entries occupied |
| wake_valid | input | 1 | Wakeup tag bus valid |
| wake_tag | input | 3 | Wakeup tag |
| grant_valid | output | 1 | An entry was granted this cycle |
| grant_idx | output | 2 | Index of the granted entry |
| grant_seq | output | 1 | Granted entry needs two port reads |
| rf_ren | output | 1 | Register-file read enable |
| rf_raddr | output | 3 | Register-file read address |
| rf_rdata | input | 16 | Read data, one cycle after the address |
| byp_data | input | 16 | Bypass value for a source woken in the grant cycle |
| bcast_valid | output | 1 | Destination broadcast valid |
| bcast_tag | output | 3 | Broadcast destination tag |
| op_valid | output | 1 | Operands presented |
| op_a | output | 16 | Operand A |
| op_b | output | 16 | Operand B |

## Verification
The hardest case to reach is an instruction whose last source wakes in one cycle but which is granted only in a later one. From the ports this looks like an ordinary ready instruction, yet it must take the two-read path. The bench creates it by queueing a lower-index instruction that waits on the same tag. When that tag is broadcast, the lower-index entry wins the pick and the target is pushed into the next cycle. A second test closes the loop from `bcast_tag` back to the wakeup bus so the delayed broadcast visibly delays the dependant's grant.

// File: rtl/srq_pkg.sv
package srq_pkg;
    localparam int unsigned REGS    = 8;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned ENTRIES = 4;
    localparam int unsigned TAG_W   = $clog2(REGS);
    localparam int unsigned IDX_W   = $clog2(ENTRIES);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic       vld;
        logic [1:0] nsrc;
        tag_t       src_a;
        tag_t       src_b;
        logic       rdy_a;
        logic       rdy_b;
        tag_t       dest;
    } entry_t;

    typedef struct packed {
        logic       vld;
        logic       seq;
        logic [1:0] nsrc;
        tag_t       src_a;
        tag_t       src_b;
        logic       now_a;
        logic       now_b;
        tag_t       dest;
    } issue_t;
endpackage

// File: rtl/srq_queue.sv
module srq_queue
    import srq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ins_valid,
    input  logic [1:0]          ins_nsrc,
    input  tag_t                ins_src_a,
    input  tag_t                ins_src_b,
    input  logic                ins_rdy_a,
    input  logic                ins_rdy_b,
    input  tag_t                ins_dest,
    input  logic                wake_valid,
    input  tag_t                wake_tag,
    input  logic                gnt_valid,
    input  idx_t                gnt_idx,
    output logic [ENTRIES-1:0]  req,
    output issue_t              sel,
    output logic                full
);
    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
    } q_state_t;

    q_state_t st_d, st_q;
    logic [ENTRIES-1:0] now_a, now_b, seq_bit;

    always_comb begin
        logic hit_a, hit_b, found, ins_hit_a, ins_hit_b;
        idx_t free_idx;
        st_d     = st_q;
        full     = 1'b1;
        found    = 1'b0;
        free_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            hit_a      = wake_valid && (st_q.ent[i].src_a == wake_tag);
            hit_b      = wake_valid && (st_q.ent[i].src_b == wake_tag);
            now_a[i]   = st_q.ent[i].vld && !st_q.ent[i].rdy_a && hit_a;
            now_b[i]   = st_q.ent[i].vld && !st_q.ent[i].rdy_b && hit_b;
            req[i]     = st_q.ent[i].vld && (st_q.ent[i].rdy_a || hit_a)
                                         && (st_q.ent[i].rdy_b || hit_b);
            seq_bit[i] = (st_q.ent[i].nsrc == 2'd2) && !now_a[i] && !now_b[i];
            st_d.ent[i].rdy_a = st_q.ent[i].rdy_a || hit_a;
            st_d.ent[i].rdy_b = st_q.ent[i].rdy_b || hit_b;
            if (!st_q.ent[i].vld) begin
                full = 1'b0;
                if (!found) begin
                    found    = 1'b1;
                    free_idx = idx_t'(i);
                end
            end
        end
        if (gnt_valid) st_d.ent[gnt_idx].vld = 1'b0;
        ins_hit_a = wake_valid && (ins_src_a == wake_tag);
        ins_hit_b = wake_valid && (ins_src_b == wake_tag);
        if (ins_valid && !full) begin
            st_d.ent[free_idx].vld   = 1'b1;
            st_d.ent[free_idx].nsrc  = ins_nsrc;
            st_d.ent[free_idx].src_a = ins_src_a;
            st_d.ent[free_idx].src_b = ins_src_b;
            st_d.ent[free_idx].dest  = ins_dest;
            st_d.ent[free_idx].rdy_a = ins_rdy_a || ins_hit_a || (ins_nsrc == 2'd0);
            st_d.ent[free_idx].rdy_b = ins_rdy_b || ins_hit_b || (ins_nsrc != 2'd2);
        end
        sel.vld   = gnt_valid;
        sel.seq   = seq_bit[gnt_idx];
        sel.nsrc  = st_q.ent[gnt_idx].nsrc;
        sel.src_a = st_q.ent[gnt_idx].src_a;
        sel.src_b = st_q.ent[gnt_idx].src_b;
        sel.now_a = now_a[gnt_idx];
        sel.now_b = now_b[gnt_idx];
        sel.dest  = st_q.ent[gnt_idx].dest;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/srq_pick.sv
module srq_pick
    import srq_pkg::*;
(
    input  logic [ENTRIES-1:0] req,
    input  logic               block,
    output logic               gnt_valid,
    output idx_t               gnt_idx
);
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i] && !block) begin
                gnt_valid = 1'b1;
                gnt_idx   = idx_t'(i);
            end
        end
    end
endmodule

// File: rtl/srq_rdseq.sv
module srq_rdseq
    import srq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  issue_t sel,
    input  data_t  rf_rdata,
    input  data_t  byp_data,
    output logic   block,
    output logic   rf_ren,
    output tag_t   rf_raddr,
    output logic   bcast_valid,
    output tag_t   bcast_tag,
    output logic   op_valid,
    output data_t  op_a,
    output data_t  op_b
);
    typedef struct packed {
        issue_t s1;
        issue_t s2;
        logic   s3_vld;
        data_t  hold;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        logic s2_seq;
        s2_seq      = st_q.s2.vld && st_q.s2.seq;
        st_d        = st_q;
        st_d.s1     = sel;
        st_d.s2     = st_q.s1;
        st_d.s3_vld = s2_seq;
        if (s2_seq) st_d.hold = rf_rdata;

        block    = st_q.s1.vld && st_q.s1.seq;
        rf_ren   = 1'b0;
        rf_raddr = '0;
        if (st_q.s1.vld) begin
            if (st_q.s1.seq) begin
                rf_ren   = 1'b1;
                rf_raddr = st_q.s1.src_a;
            end else if (st_q.s1.nsrc != 2'd0 && !st_q.s1.now_a) begin
                rf_ren   = 1'b1;
                rf_raddr = st_q.s1.src_a;
            end else if (st_q.s1.nsrc == 2'd2 && !st_q.s1.now_b) begin
                rf_ren   = 1'b1;
                rf_raddr = st_q.s1.src_b;
            end
        end else if (s2_seq) begin
            rf_ren   = 1'b1;
            rf_raddr = st_q.s2.src_b;
        end

        bcast_valid = 1'b0;
        bcast_tag   = '0;
        if (st_q.s1.vld && !st_q.s1.seq) begin
            bcast_valid = 1'b1;
            bcast_tag   = st_q.s1.dest;
        end else if (s2_seq) begin
            bcast_valid = 1'b1;
            bcast_tag   = st_q.s2.dest;
        end

        op_valid = 1'b0;
        op_a     = '0;
        op_b     = '0;
        if (st_q.s3_vld) begin
            op_valid = 1'b1;
            op_a     = st_q.hold;
            op_b     = rf_rdata;
        end else if (st_q.s2.vld && !st_q.s2.seq) begin
            op_valid = 1'b1;
            if (st_q.s2.nsrc != 2'd0) op_a = st_q.s2.now_a ? byp_data : rf_rdata;
            if (st_q.s2.nsrc == 2'd2) op_b = st_q.s2.now_b ? byp_data : rf_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/seqread_sched.sv
module seqread_sched
    import srq_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ins_valid,
    input  logic [1:0]                   ins_nsrc,
    input  logic [srq_pkg::TAG_W-1:0]    ins_src_a,
    input  logic [srq_pkg::TAG_W-1:0]    ins_src_b,
    input  logic                         ins_rdy_a,
    input  logic                         ins_rdy_b,
    input  logic [srq_pkg::TAG_W-1:0]    ins_dest,
    output logic                         q_full,
    input  logic                         wake_valid,
    input  logic [srq_pkg::TAG_W-1:0]    wake_tag,
    output logic                         grant_valid,
    output logic [srq_pkg::IDX_W-1:0]    grant_idx,
    output logic                         grant_seq,
    output logic                         rf_ren,
    output logic [srq_pkg::TAG_W-1:0]    rf_raddr,
    input  logic [srq_pkg::DATA_W-1:0]   rf_rdata,
    input  logic [srq_pkg::DATA_W-1:0]   byp_data,
    output logic                         bcast_valid,
    output logic [srq_pkg::TAG_W-1:0]    bcast_tag,
    output logic                         op_valid,
    output logic [srq_pkg::DATA_W-1:0]   op_a,
    output logic [srq_pkg::DATA_W-1:0]   op_b
);
    logic [ENTRIES-1:0] req;
    logic               block;
    issue_t             sel;

    srq_queue u_queue (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_nsrc(ins_nsrc),
        .ins_src_a(ins_src_a), .ins_src_b(ins_src_b),
        .ins_rdy_a(ins_rdy_a), .ins_rdy_b(ins_rdy_b), .ins_dest(ins_dest),
        .wake_valid(wake_valid), .wake_tag(wake_tag),
        .gnt_valid(grant_valid), .gnt_idx(grant_idx),
        .req(req), .sel(sel), .full(q_full)
    );

    srq_pick u_pick (
        .req(req), .block(block),
        .gnt_valid(grant_valid), .gnt_idx(grant_idx)
    );

    assign grant_seq = grant_valid && sel.seq;

    srq_rdseq u_rdseq (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .rf_rdata(rf_rdata), .byp_data(byp_data), .block(block),
        .rf_ren(rf_ren), .rf_raddr(rf_raddr),
        .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
        .op_valid(op_valid), .op_a(op_a), .op_b(op_b)
    );
endmodule

// File: rtl/seqread_sched_chk.sv
module seqread_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic grant_valid,
    input logic grant_seq,
    input logic rf_ren,
    input logic bcast_valid,
    input logic op_valid
);
    AST_SEQ_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && grant_seq |=> !grant_valid); // R5
    AST_SEQ_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && grant_seq |=> rf_ren ##1 rf_ren); // R4
    AST_SEQ_LATE_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && grant_seq |=> !bcast_valid ##1 bcast_valid); // R6
    AST_SEQ_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && grant_seq |=> ##2 op_valid); // R4
    AST_FAST_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !grant_seq |=> bcast_valid); // R3
    AST_FAST_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !grant_seq |=> ##1 op_valid); // R3
endmodule

bind seqread_sched seqread_sched_chk u_chk (
    .clk(clk), .rst_n(rst_n), .grant_valid(grant_valid),
    .grant_seq(grant_seq), .rf_ren(rf_ren),
    .bcast_valid(bcast_valid), .op_valid(op_valid)
);

// File: tb/seqread_sched_tb_top.sv
module seqread_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [1:0]  ins_nsrc = '0;
    logic [2:0]  ins_src_a = '0, ins_src_b = '0, ins_dest = '0;
    logic        ins_rdy_a = 1'b0, ins_rdy_b = 1'b0;
    logic        q_full;
    logic        drv_wake_v = 1'b0, loop_en = 1'b0;
    logic [2:0]  drv_wake_t = '0;
    logic        wake_valid;
    logic [2:0]  wake_tag;
    logic        grant_valid, grant_seq, rf_ren, bcast_valid, op_valid;
    logic [1:0]  grant_idx;
    logic [2:0]  rf_raddr, bcast_tag;
    logic [15:0] rf_rdata = '0;
    logic [15:0] byp_data = 16'hB0B0;
    logic [15:0] op_a, op_b;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    assign wake_valid = loop_en ? bcast_valid : drv_wake_v;
    assign wake_tag   = loop_en ? bcast_tag   : drv_wake_t;

    function automatic logic [15:0] regval(input logic [2:0] r);
        return 16'h1000 + 16'(r) * 16'h0101;
    endfunction

    always_ff @(posedge clk) if (rf_ren) rf_rdata <= regval(rf_raddr);

    seqread_sched dut_i (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        ins_valid  = 1'b0;
        drv_wake_v = 1'b0;
    endtask

    task automatic put(input logic [1:0] n, input logic [2:0] a, input logic [2:0] b,
                       input logic ra, input logic rb, input logic [2:0] d);
        ins_valid = 1'b1; ins_nsrc = n; ins_src_a = a; ins_src_b = b;
        ins_rdy_a = ra; ins_rdy_b = rb; ins_dest = d;
    endtask

    task automatic wake(input logic [2:0] t);
        drv_wake_v = 1'b1; drv_wake_t = t;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic t_reset();
        step(); #1;
        chk("R1", "grant", grant_valid, 0);
        chk("R1", "bcast", bcast_valid, 0);
        chk("R1", "ren", rf_ren, 0);
        chk("R1", "opv", op_valid, 0);
        chk("R1", "full", q_full, 0);
    endtask

    task automatic t_one_src();
        step(); put(2'd1, 3'd2, 3'd0, 1, 0, 3'd3); #1;
        chk("R2", "no grant in insert cycle", grant_valid, 0);
        step(); #1;
        chk("R2", "grant", grant_valid, 1);
        chk("R7", "one-src not seq", grant_seq, 0);
        step(); #1;
        chk("R3", "ren", rf_ren, 1);
        chk("R3", "raddr", rf_raddr, 2);
        chk("R3", "bcast", {bcast_valid, bcast_tag}, {1'b1, 3'd3});
        step(); #1;
        chk("R3", "opv", op_valid, 1);
        chk("R3", "op_a", op_a, regval(3'd2));
        chk("R7", "unused op_b zero", op_b, 0);
        idle(2);
    endtask

    task automatic t_zero_src();
        step(); put(2'd0, 3'd5, 3'd6, 0, 0, 3'd2);
        step(); #1;
        chk("R7", "zero-src grant", {grant_valid, grant_seq}, 2'b10);
        step(); #1;
        chk("R7", "zero-src no read", rf_ren, 0);
        chk("R3", "bcast", {bcast_valid, bcast_tag}, {1'b1, 3'd2});
        step(); #1;
        chk("R7", "ops zero", {op_valid, op_a, op_b}, {1'b1, 32'h0});
        idle(2);
    endtask

    task automatic t_seq_bubble();
        step(); put(2'd2, 3'd1, 3'd2, 1, 1, 3'd6);
        step(); put(2'd1, 3'd3, 3'd0, 1, 0, 3'd7); #1;
        chk("R4", "seq grant", {grant_valid, grant_seq}, 2'b11);
        step(); #1;
        chk("R5", "bubble", grant_valid, 0);
        chk("R4", "first read", {rf_ren, rf_raddr}, {1'b1, 3'd1});
        chk("R6", "no bcast T+1", bcast_valid, 0);
        step(); #1;
        chk("R5", "grant resumes", {grant_valid, grant_seq}, 2'b10);
        chk("R4", "second read", {rf_ren, rf_raddr}, {1'b1, 3'd2});
        chk("R6", "bcast T+2", {bcast_valid, bcast_tag}, {1'b1, 3'd6});
        step(); #1;
        chk("R4", "seq ops", {op_valid, op_a, op_b}, {1'b1, regval(3'd1), regval(3'd2)});
        chk("R3", "next read", {rf_ren, rf_raddr}, {1'b1, 3'd3});
        step(); #1;
        chk("R3", "next op", {op_valid, op_a, op_b}, {1'b1, regval(3'd3), 16'h0});
        idle(2);
    endtask

    task automatic t_back_to_back();
        step(); put(2'd2, 3'd5, 3'd4, 0, 1, 3'd1);
        step(); wake(3'd5); #1;
        chk("R3", "b2b grant not seq", {grant_valid, grant_seq}, 2'b10);
        step(); #1;
        chk("R3", "read other src", {rf_ren, rf_raddr}, {1'b1, 3'd4});
        step(); #1;
        chk("R3", "bypass op", {op_valid, op_a, op_b}, {1'b1, byp_data, regval(3'd4)});
        idle(2);
    endtask

    task automatic t_two_wakes();
        step(); put(2'd2, 3'd5, 3'd6, 0, 0, 3'd4);
        step(); wake(3'd5); #1;
        chk("R2", "half ready no grant", grant_valid, 0);
        step(); wake(3'd6); #1;
        chk("R3", "last wake b2b", {grant_valid, grant_seq}, 2'b10);
        step(); #1;
        chk("R3", "reads earlier src", {rf_ren, rf_raddr}, {1'b1, 3'd5});
        step(); #1;
        chk("R3", "ops", {op_valid, op_a, op_b}, {1'b1, regval(3'd5), byp_data});
        idle(2);
    endtask

    task automatic t_late_select();
        step(); put(2'd1, 3'd6, 3'd0, 0, 0, 3'd1);
        step(); put(2'd2, 3'd6, 3'd4, 0, 1, 3'd2);
        step(); wake(3'd6); #1;
        chk("R2", "lowest index wins", {grant_valid, grant_idx, grant_seq}, 4'b1000);
        step(); #1;
        chk("R9", "late select is seq", {grant_valid, grant_idx, grant_seq}, 4'b1011);
        chk("R3", "bypassed one-src no read", rf_ren, 0);
        step(); #1;
        chk("R9", "first read", {rf_ren, rf_raddr}, {1'b1, 3'd6});
        chk("R3", "one-src bypass op", {op_valid, op_a}, {1'b1, byp_data});
        step(); #1;
        chk("R9", "second read", {rf_ren, rf_raddr}, {1'b1, 3'd4});
        chk("R6", "late bcast", {bcast_valid, bcast_tag}, {1'b1, 3'd2});
        step(); #1;
        chk("R9", "ops", {op_valid, op_a, op_b}, {1'b1, regval(3'd6), regval(3'd4)});
        idle(2);
    endtask

    task automatic t_dependant();
        loop_en = 1'b1;
        step(); put(2'd2, 3'd1, 3'd2, 1, 1, 3'd3);
        step(); put(2'd2, 3'd3, 3'd4, 0, 1, 3'd5); #1;
        chk("R4", "producer seq", {grant_valid, grant_seq}, 2'b11);
        step(); #1;
        chk("R6", "dependant not yet", grant_valid, 0);
        step(); #1;
        chk("R6", "dependant grant at +2", {grant_valid, grant_idx, grant_seq}, 4'b1010);
        chk("R6", "producer bcast", {bcast_valid, bcast_tag}, {1'b1, 3'd3});
        step(); #1;
        chk("R4", "producer ops", {op_valid, op_a, op_b}, {1'b1, regval(3'd1), regval(3'd2)});
        chk("R3", "dependant read", {rf_ren, rf_raddr}, {1'b1, 3'd4});
        step(); #1;
        chk("R3", "dependant ops", {op_valid, op_a, op_b}, {1'b1, byp_data, regval(3'd4)});
        loop_en = 1'b0;
        idle(2);
    endtask

    task automatic t_full();
        int grants = 0;
        for (int i = 0; i < 4; i++) begin
            step(); put(2'd1, 3'd7, 3'd0, 0, 0, 3'(i));
        end
        step(); put(2'd0, 3'd0, 3'd0, 1, 1, 3'd6); #1;
        chk("R8", "full", q_full, 1);
        step(); #1;
        chk("R8", "insert when full ignored", grant_valid, 0);
        chk("R8", "still full", q_full, 1);
        step(); wake(3'd7); #1;
        if (grant_valid) grants++;
        for (int i = 0; i < 6; i++) begin
            step(); #1;
            if (grant_valid) grants++;
        end
        chk("R8", "grant count", grants, 4);
        chk("R8", "drained", q_full, 0);
        idle(3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_one_src();
        t_zero_src();
        t_seq_bubble();
        t_back_to_back();
        t_two_wakes();
        t_late_select();
        t_dependant();
        t_full();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule